// File: doc/BRIEF.md
# Receive Word Queue with Masked Status Interrupt

This block buffers 32-bit words that arrive from a card-side data path until a bus-side agent (software or a DMA engine) collects them. Words enter on a one-cycle push strobe and leave, oldest first, through a data register whose read removes the word it returns. The queue holds 32 words. It also has registers for status, a write-1-to-clear register and an interrupt mask.

Five live conditions are tracked:

- the queue is full;
- the queue is empty;
- a fill threshold of eight words has been reached;
- data is available;
- a sticky overrun has occurred. An overrun is a push that met a full queue and was discarded.

The threshold condition also drives a DMA request line, so a DMA engine can fetch the queue in bursts of four words. A level interrupt is raised while any status condition is high and its mask bit is set. Status flags and the interrupt are registered. They show the occupancy left by the most recent clock edge.

Register word index on `bus_addr`: 0 status (read-only), 1 clear (write-1-to-clear), 2 mask (read/write), 3 data (a read pops). Status and mask share one bit layout: bit 0 full, bit 1 empty, bit 2 threshold, bit 3 available, bit 4 overrun. Unused upper bits read as zero.

Top module: `rx_word_queue`

## Requirements
- R1: Status bit 0 (full) is 1 exactly when 32 words are held.
- R2: Status bit 1 (empty) is 1 exactly when no word is held.
- R3: Status bit 2 (threshold) is 1 exactly when 8 or more words are held, and `dma_req` always equals it.
- R4: Status bit 3 (available) is always the inverse of status bit 1.
- R5: A push while 32 words are held and no pop happens in the same cycle sets status bit 4 (overrun). The pushed word is discarded, and the stored words and their count do not change.
- R6: Status bit 4 stays 1 until a write to index 1 with data bit 4 set. Clear writes with bit 4 at 0 leave it set. When a new overrun and a clear happen in the same cycle, the overrun wins.
- R7: `irq` is 1 exactly when the bitwise AND of status and the mask register (index 2, low 5 bits) is nonzero.
- R8: A read of index 3 returns the oldest held word and removes it, so words leave in arrival order.
- R9: A read of index 3 while empty returns 0. It changes no state and sets no error.
- R10: A push and a pop in the same cycle both complete and leave the count unchanged, including when the queue is full, where no overrun is raised.
- R11: Status, `irq` and `dma_req` change only after the clock edge that samples the push or pop. A status read in the same cycle as a push still shows the earlier occupancy.
- R12: After reset, status reads 0x2, the mask reads 0, and `irq` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Card side: push `push_data` this cycle |
| push_data | input | 32 | Card side: word to enqueue |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | DMA burst request (threshold reached) |

## Verification
The queue is first driven through directed fills and drains:

- Filling to 7 and then 8 words separates the threshold from an off-by-one.
- Filling exactly to 32 and pushing one more separates the full edge from overrun, and proves that the dropped word never appears on a later pop.
- Pops at full with a concurrent push separate a correct simultaneous operation from a false overrun.
- Pops past empty separate a clean zero read from pointer corruption.
- Clears with and without bit 4, including one that collides with a new overrun, separate sticky set-priority behaviour from a plain register.

A seeded random phase then mixes pushes with every bus access, including random mask and clear values, at first with pushes favoured and then with pops favoured. This sweeps occupancy repeatedly across the empty, threshold and full edges, and compares every popped word, status read and interrupt level against a bench queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLAG_N    = 5;
  localparam int FLAG_FULL = 0;
  localparam int FLAG_EMPT = 1;
  localparam int FLAG_THR  = 2;
  localparam int FLAG_AVL  = 3;
  localparam int FLAG_OVR  = 4;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_MASK   = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter  int DEPTH = 32,
  parameter  int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head_data,
  output logic             head_valid,
  output logic [CNT_W-1:0] cnt_next,
  output logic             drop_evt
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_full, is_empty, do_push, do_pop;
  logic [WIDTH-1:0] slots [DEPTH];

  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign do_pop   = pop_req & ~is_empty;
  assign do_push  = push_req & (~is_full | do_pop);
  assign drop_evt = push_req & is_full & ~do_pop;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push)
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic             slot_we;
    logic [WIDTH-1:0] slot_q;
    assign slot_we = do_push && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= push_data;
    end
    assign slots[e] = slot_q;
  end

  assign head_data  = slots[rd_ptr_q];
  assign head_valid = ~is_empty;
  assign cnt_next   = cnt_d;
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_next,
  input  logic              ovr_set,
  input  logic              ovr_clr,
  input  logic [FLAG_N-1:0] mask_next,
  output logic [FLAG_N-1:0] flags_q,
  output logic              irq_q
);
  logic [FLAG_N-1:0] flags_d;
  logic              irq_d;

  always_comb begin
    flags_d            = '0;
    flags_d[FLAG_FULL] = (cnt_next == CNT_W'(DEPTH));
    flags_d[FLAG_EMPT] = (cnt_next == '0);
    flags_d[FLAG_THR]  = (cnt_next >= CNT_W'(THRESH));
    flags_d[FLAG_AVL]  = (cnt_next != '0);
    flags_d[FLAG_OVR]  = ovr_set | (flags_q[FLAG_OVR] & ~ovr_clr);
    irq_d              = |(flags_d & mask_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAG_N'(1) << FLAG_EMPT;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [FLAG_N-1:0] flags_q,
  input  logic [WIDTH-1:0]  head_data,
  input  logic              head_valid,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              pop_req,
  output logic              ovr_clr,
  output logic [FLAG_N-1:0] mask_q,
  output logic [FLAG_N-1:0] mask_next
);
  reg_sel_e sel;
  logic     rd_en, wr_en, mask_we;

  assign sel     = reg_sel_e'(bus_addr);
  assign rd_en   = bus_sel & ~bus_write;
  assign wr_en   = bus_sel & bus_write;
  assign pop_req = rd_en & (sel == REG_DATA);
  assign ovr_clr = wr_en & (sel == REG_CLEAR) & bus_wdata[FLAG_OVR];
  assign mask_we = wr_en & (sel == REG_MASK);

  always_comb begin
    mask_next = mask_q;
    if (mask_we) mask_next = bus_wdata[FLAG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        REG_STATUS: bus_rdata = WIDTH'(flags_q);
        REG_MASK:   bus_rdata = WIDTH'(mask_q);
        REG_DATA:   bus_rdata = head_valid ? head_data : '0;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_word_queue.sv
module rx_word_queue
  import rxq_pkg::*;
#(
  parameter  int DEPTH  = 32,
  parameter  int WIDTH  = 32,
  parameter  int THRESH = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             bus_sel,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             irq,
  output logic             dma_req
);
  logic              rst_n_int;
  logic [WIDTH-1:0]  head_data;
  logic              head_valid, pop_req, drop_evt, ovr_clr, irq_q;
  logic [CNT_W-1:0]  cnt_next;
  logic [FLAG_N-1:0] flags_q, mask_q, mask_next;

  rxq_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .push_req   (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .head_data  (head_data),
    .head_valid (head_valid),
    .cnt_next   (cnt_next),
    .drop_evt   (drop_evt)
  );

  rxq_flags #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cnt_next  (cnt_next),
    .ovr_set   (drop_evt),
    .ovr_clr   (ovr_clr),
    .mask_next (mask_next),
    .flags_q   (flags_q),
    .irq_q     (irq_q)
  );

  rxq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bus_sel    (bus_sel),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flags_q    (flags_q),
    .head_data  (head_data),
    .head_valid (head_valid),
    .bus_rdata  (bus_rdata),
    .pop_req    (pop_req),
    .ovr_clr    (ovr_clr),
    .mask_q     (mask_q),
    .mask_next  (mask_next)
  );

  assign irq     = irq_q;
  assign dma_req = flags_q[FLAG_THR];
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAG_N-1:0] flags_q,
  input logic [FLAG_N-1:0] mask_q,
  input logic              irq,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [1:0]        bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata
);
  logic clr_hit, empty_pop;
  assign clr_hit   = bus_sel && bus_write && (bus_addr == REG_CLEAR) && bus_wdata[FLAG_OVR];
  assign empty_pop = bus_sel && !bus_write && (bus_addr == REG_DATA) && flags_q[FLAG_EMPT];

  a_r4_avail_inverts_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FLAG_AVL] == !flags_q[FLAG_EMPT]);

  a_r1_full_implies_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FLAG_FULL] |-> (flags_q[FLAG_THR] && !flags_q[FLAG_EMPT]));

  a_r2_empty_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FLAG_EMPT] |-> (!flags_q[FLAG_THR] && !flags_q[FLAG_FULL]));

  a_r7_irq_masked_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(flags_q & mask_q));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLAG_OVR] && !clr_hit) |=> flags_q[FLAG_OVR]);

  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty_pop |-> (bus_rdata == '0));
endmodule

bind rx_word_queue rxq_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flags_q   (flags_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .bus_sel   (bus_sel),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/rx_word_queue_tb.sv
`timescale 1ns/1ps
module rx_word_queue_tb;
  logic        clk, rst_n;
  logic        push_valid;
  logic [31:0] push_data;
  logic        bus_sel, bus_write;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] mq[$];
  logic        movr;
  logic [4:0]  mmask;

  rx_word_queue u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [4:0] exp_flags();
    int n = mq.size();
    return {movr, (n != 0), (n >= 8), (n == 0), (n == 32)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_status(input logic [31:0] act);
    logic [4:0] e = exp_flags();
    chk(act[0] == e[0], "R1 full bit", act, {27'd0, e});
    chk(act[1] == e[1], "R2 empty bit", act, {27'd0, e});
    chk(act[2] == e[2], "R3 threshold bit", act, {27'd0, e});
    chk(act[3] == e[3], "R4 available bit", act, {27'd0, e});
    chk(act[4] == e[4], "R5 R6 overrun bit", act, {27'd0, e});
    chk(act[31:5] == 27'd0, "R11 status upper bits", act, {27'd0, e});
  endtask

  // One cycle: inputs set after a falling edge, checked before and after the rising edge.
  task automatic cyc(input logic pv, input logic [31:0] pd, input logic sel,
                     input logic wr, input logic [1:0] adr, input logic [31:0] wd);
    logic pop, setv;
    logic [31:0] expd;
    push_valid = pv; push_data = pd;
    bus_sel = sel; bus_write = wr; bus_addr = adr; bus_wdata = wd;
    #2;
    if (sel && !wr && adr == 2'd0) check_status(bus_rdata);
    if (sel && !wr && adr == 2'd2) chk(bus_rdata == {27'd0, mmask}, "R7 mask readback", bus_rdata, {27'd0, mmask});
    if (sel && !wr && adr == 2'd3) begin
      expd = (mq.size() != 0) ? mq[0] : 32'd0;
      chk(bus_rdata == expd, (mq.size() != 0) ? "R8 popped word" : "R9 empty pop zero", bus_rdata, expd);
    end
    @(posedge clk);
    pop  = sel && !wr && adr == 2'd3 && mq.size() != 0;
    setv = 1'b0;
    if (pop) void'(mq.pop_front());
    if (pv) begin
      if (mq.size() == 32) setv = 1'b1;
      else mq.push_back(pd);
    end
    if (setv) movr = 1'b1;
    else if (sel && wr && adr == 2'd1 && wd[4]) movr = 1'b0;
    if (sel && wr && adr == 2'd2) mmask = wd[4:0];
    @(negedge clk);
    push_valid = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
    chk(irq == |(exp_flags() & mmask), "R7 irq level", {31'd0, irq}, {31'd0, |(exp_flags() & mmask)});
    chk(dma_req == (mq.size() >= 8), "R3 dma_req", {31'd0, dma_req}, {31'd0, mq.size() >= 8});
  endtask

  task automatic rd_status(); cyc(1'b0, 32'd0, 1'b1, 1'b0, 2'd0, 32'd0); endtask
  task automatic push_w(input logic [31:0] d); cyc(1'b1, d, 1'b0, 1'b0, 2'd0, 32'd0); endtask
  task automatic pop_w(); cyc(1'b0, 32'd0, 1'b1, 1'b0, 2'd3, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0;
    bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    movr = 1'b0; mmask = '0;
    r = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(irq == 1'b0, "R12 irq after reset", {31'd0, irq}, 32'd0);
    chk(dma_req == 1'b0, "R12 dma_req after reset", {31'd0, dma_req}, 32'd0);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 2'd0; #2;
    chk(bus_rdata == 32'h2, "R12 status after reset", bus_rdata, 32'h2);
    bus_addr = 2'd2; #2;
    chk(bus_rdata == 32'h0, "R12 mask after reset", bus_rdata, 32'h0);
    bus_sel = 1'b0;
    @(negedge clk);

    // R7 mask selects empty flag, then none
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd2, 32'h0000_0002);
    chk(irq == 1'b1, "R7 irq on masked empty", {31'd0, irq}, 32'd1);
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd2, 32'h0000_0000);
    chk(irq == 1'b0, "R7 irq cleared by mask", {31'd0, irq}, 32'd0);

    // R11 status read in push cycle shows prior occupancy
    cyc(1'b1, 32'hA000_0000, 1'b1, 1'b0, 2'd0, 0);
    for (int i = 1; i < 7; i++) push_w(32'hA000_0000 + i);
    chk(dma_req == 1'b0, "R3 seven words below threshold", {31'd0, dma_req}, 32'd0);
    push_w(32'hA000_0007);
    chk(dma_req == 1'b1, "R3 eight words reach threshold", {31'd0, dma_req}, 32'd1);
    for (int i = 8; i < 32; i++) push_w(32'hA000_0000 + i);
    rd_status();
    // R5 overrun drop
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd2, 32'h0000_0010);
    push_w(32'hDEAD_BEEF);
    chk(irq == 1'b1, "R5 overrun raises masked irq", {31'd0, irq}, 32'd1);
    rd_status();
    pop_w();
    push_w(32'hB000_0000);
    // R10 push and pop together at full
    cyc(1'b1, 32'hB000_0001, 1'b1, 1'b0, 2'd3, 0);
    rd_status();
    // R6 clear without bit 4 keeps overrun, with bit 4 clears it
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd1, 32'h0000_000F);
    chk(irq == 1'b1, "R6 overrun kept by other clear bits", {31'd0, irq}, 32'd1);
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd1, 32'h0000_0010);
    chk(irq == 1'b0, "R6 overrun cleared", {31'd0, irq}, 32'd0);
    // R6 set wins over clear in same cycle
    cyc(1'b1, 32'hCAFE_0000, 1'b1, 1'b1, 2'd1, 32'h0000_0010);
    chk(irq == 1'b1, "R6 set wins over clear", {31'd0, irq}, 32'd1);
    cyc(1'b0, 0, 1'b1, 1'b1, 2'd1, 32'h0000_0010);
    // R8 drain in order, R9 pops past empty
    for (int i = 0; i < 34; i++) pop_w();
    rd_status();
    chk(irq == 1'b0, "R9 empty pops raise no error", {31'd0, irq}, 32'd0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned pp = (i < 2000) ? 70 : 30;
      logic pv = ($urandom % 100) < pp;
      logic [31:0] pd = $urandom;
      int unsigned op = $urandom % 8;
      case (op)
        0, 1:    cyc(pv, pd, 1'b1, 1'b0, 2'd0, 0);
        2, 3, 4: cyc(pv, pd, 1'b1, 1'b0, 2'd3, 0);
        5:       cyc(pv, pd, 1'b1, 1'b1, 2'd2, $urandom);
        6:       cyc(pv, pd, 1'b1, 1'b1, 2'd1, $urandom);
        default: cyc(pv, pd, 1'b1, 1'b0, 2'd2, 0);
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule